// File: doc/BRIEF.md
# USB Endpoint Control Register Bank

This block sits between a small CPU and the packet engine of a USB device controller that serves four IN and four OUT endpoints. The CPU sees sixteen byte-wide locations. Through them it loads transmit byte counts, arms IN buffers, releases OUT buffers, selects the DATA0/DATA1 PID for each IN endpoint, programs the device address and acknowledges interrupts. The packet engine uses the ready flags to decide between ACK and NAK, and it reports sent buffers, received packets, start-of-frame tokens and setup packets.

Each IN endpoint is a two-state machine. `IN_IDLE` moves to `IN_ARMED` on a CPU arm request. `IN_ARMED` returns to `IN_IDLE` when the core reports the buffer sent, unless the CPU arms the endpoint again in that same cycle. Each OUT endpoint is a two-state machine as well. `OUT_FREE` moves to `OUT_FULL` when a packet is accepted, and the byte count is captured at that point. `OUT_FULL` returns to `OUT_FREE` when the CPU releases the buffer. One side owns each transition. The CPU cannot withdraw an armed IN buffer. The core cannot release an OUT buffer.

A four-bit interrupt status register collects the events. Writing 1 to a bit clears it, and a new event in the same cycle as the clear keeps the bit set. The interrupt output is high while any status bit is set.

Top module: `usb_ep_regbank`

## Requirements
- R1: After reset every readable location returns 0, `dev_addr` is 0 and `irq` is low.
- R2: Writing address 0x0+n (n = 0..3) stores the IN byte count of endpoint n. The count reads back at that address and drives `in_len` while `in_tok_ep` = n.
- R3: Writing address 0x8 sets the IN-ready bit n for each data bit n (3:0) that is 1. Data bits that are 0 leave their flag unchanged. Reading 0x8 returns the flags in bits 3:0.
- R4: `in_ack` is 1 when the IN-ready flag of endpoint `in_tok_ep` is 1, and 0 (NAK) otherwise.
- R5: An `in_done` pulse for an armed endpoint clears its IN-ready flag and sets status bit 2. For an endpoint that is not armed the pulse has no effect. A CPU arm of the same endpoint in the same cycle keeps the flag set.
- R6: An `out_rx` pulse for an endpoint whose OUT-ready flag is 0 is acknowledged (`out_ack` = 1). It stores `out_rx_len` at address 0x4+n, sets the flag and sets status bit 3. If the flag is 1, the packet is NAKed and the count, flag and status bit 3 are unchanged.
- R7: Writing address 0x9 clears the OUT-ready bit n for each data bit that is 1. Data bits that are 0 are ignored. Reading 0x9 returns the flags in bits 3:0.
- R8: Status register 0xA: bit 0 start-of-frame, bit 1 setup received, bit 2 IN buffer sent, bit 3 OUT buffer received. Writing 1 to a bit clears it. An event in the same cycle as the clear leaves the bit set.
- R9: `irq` is 1 exactly when any status bit is 1.
- R10: Register 0xB holds one PID select bit per IN endpoint (0 = DATA0, 1 = DATA1). It drives `in_pid_sel` for endpoint `in_tok_ep` and changes only on a CPU write.
- R11: Register 0xC holds the 7-bit device address, written from data bits 6:0. It drives `dev_addr` and changes only on a CPU write.
- R12: A `sof_valid` pulse captures the 11-bit `sof_frame`. Address 0xD returns bits 7:0 and address 0xE returns bits 10:8 in bits 2:0.
- R13: Address 0xF and all unused upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 4 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational from `cpu_addr`) |
| in_tok_ep | input | 2 | Endpoint of the current IN token |
| in_ack | output | 1 | 1 = send data, 0 = NAK |
| in_len | output | 8 | Byte count for `in_tok_ep` |
| in_pid_sel | output | 1 | 0 = DATA0, 1 = DATA1 for `in_tok_ep` |
| in_done | input | 1 | Core finished sending an IN buffer |
| in_done_ep | input | 2 | Endpoint of `in_done` |
| out_rx | input | 1 | Core received an OUT packet |
| out_rx_ep | input | 2 | Endpoint of the OUT packet |
| out_rx_len | input | 8 | Received byte count |
| out_ack | output | 1 | 1 = accept, 0 = NAK for `out_rx_ep` |
| sof_valid | input | 1 | Start-of-frame token seen |
| sof_frame | input | 11 | Frame number of that token |
| setup_valid | input | 1 | Setup data received |
| dev_addr | output | 7 | Programmed device address |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the ownership split of the ready flags. The CPU never clears an IN flag, and a sent armed buffer is disarmed unless it is re-armed in the same cycle. An acknowledged OUT packet leaves its flag set. Each event sets its status bit, an interrupt rises only after an event, and the PID selects and device address change only on their writes. The bench scenarios alone show the data values that cannot be expressed as simple properties:
- stored byte counts and the count retained on a NAKed packet;
- the frame number split across two addresses;
- the mixed-cycle orderings that random stimulus produces against the reference model.

// File: rtl/usb_ep_regbank_pkg.sv
package usb_ep_regbank_pkg;
    localparam int DATA_W = 8;

    // Address map; 0x0-0x3 and 0x4-0x7 are decoded by addr[3:2]
    localparam logic [3:0] A_IN_CNT  = 4'h0;
    localparam logic [3:0] A_OUT_CNT = 4'h4;
    localparam logic [3:0] A_IN_RDY  = 4'h8;
    localparam logic [3:0] A_OUT_RDY = 4'h9;
    localparam logic [3:0] A_IRQ     = 4'hA;
    localparam logic [3:0] A_TOGGLE  = 4'hB;
    localparam logic [3:0] A_DEVADR  = 4'hC;
    localparam logic [3:0] A_FRM_LO  = 4'hD;
    localparam logic [3:0] A_FRM_HI  = 4'hE;

    // Interrupt status bit positions
    localparam int IRQ_SOF   = 0;
    localparam int IRQ_SETUP = 1;
    localparam int IRQ_IN    = 2;
    localparam int IRQ_OUT   = 3;
    localparam int IRQ_N     = 4;

    typedef enum logic {IN_IDLE, IN_ARMED} in_state_e;
    typedef enum logic {OUT_FREE, OUT_FULL} out_state_e;
endpackage

// File: rtl/ep_in_slot.sv
module ep_in_slot
    import usb_ep_regbank_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             sent,
    output logic             ready,
    output logic [CNT_W-1:0] count,
    output logic             sent_ok
);
    in_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IN_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (cnt_we) count <= cnt_wdata;
    end

    // Transitions: IN_IDLE -arm-> IN_ARMED; IN_ARMED -sent & !arm-> IN_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IN_IDLE:  if (arm) state_d = IN_ARMED;
            IN_ARMED: if (sent && !arm) state_d = IN_IDLE;
        endcase
    end

    always_comb begin
        ready   = (state_q == IN_ARMED);
        sent_ok = (state_q == IN_ARMED) && sent;
    end
endmodule

// File: rtl/ep_out_slot.sv
module ep_out_slot
    import usb_ep_regbank_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx,
    input  logic [CNT_W-1:0] rx_len,
    input  logic             release_buf,
    output logic             full,
    output logic [CNT_W-1:0] count,
    output logic             rx_ok
);
    out_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (rx_ok) count <= rx_len;
    end

    // Transitions: OUT_FREE -rx-> OUT_FULL; OUT_FULL -release-> OUT_FREE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_FREE: if (rx) state_d = OUT_FULL;
            OUT_FULL: if (release_buf) state_d = OUT_FREE;
        endcase
    end

    always_comb begin
        full  = (state_q == OUT_FULL);
        rx_ok = (state_q == OUT_FREE) && rx;
    end
endmodule

// File: rtl/irq_status.sv
module irq_status #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_ev,
    input  logic [NSRC-1:0] clr_w1c,
    output logic [NSRC-1:0] stat,
    output logic            irq
);
    // A new event outranks a clear arriving in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= set_ev | (stat & ~clr_w1c);
    end

    assign irq = |stat;
endmodule

// File: rtl/usb_ep_regbank.sv
module usb_ep_regbank
    import usb_ep_regbank_pkg::*;
#(
    parameter int NUM_EP  = 4,
    parameter int EP_W    = $clog2(NUM_EP),
    parameter int CNT_W   = 8,
    parameter int DEV_W   = 7,
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_we,
    input  logic [3:0]         cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic [EP_W-1:0]    in_tok_ep,
    output logic               in_ack,
    output logic [CNT_W-1:0]   in_len,
    output logic               in_pid_sel,
    input  logic               in_done,
    input  logic [EP_W-1:0]    in_done_ep,
    input  logic               out_rx,
    input  logic [EP_W-1:0]    out_rx_ep,
    input  logic [CNT_W-1:0]   out_rx_len,
    output logic               out_ack,
    input  logic               sof_valid,
    input  logic [FRAME_W-1:0] sof_frame,
    input  logic               setup_valid,
    output logic [DEV_W-1:0]   dev_addr,
    output logic               irq
);
    localparam int FHI_W = FRAME_W - DATA_W;

    logic [NUM_EP-1:0] in_rdy_q, in_sent_ok, out_rdy_q, out_rx_ok;
    logic [CNT_W-1:0]  in_cnt  [NUM_EP];
    logic [CNT_W-1:0]  out_cnt [NUM_EP];
    logic [NUM_EP-1:0] toggle_q;
    logic [FRAME_W-1:0] frame_q;
    logic [IRQ_N-1:0]  irq_set, irq_clr, irq_stat_q;

    logic wr_in_rdy, wr_out_rdy;
    assign wr_in_rdy  = cpu_we && (cpu_addr == A_IN_RDY);
    assign wr_out_rdy = cpu_we && (cpu_addr == A_OUT_RDY);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        ep_in_slot #(.CNT_W(CNT_W)) u_in (
            .clk       (clk),
            .rst_n     (rst_n),
            .arm       (wr_in_rdy && cpu_wdata[g]),
            .cnt_we    (cpu_we && (cpu_addr == (A_IN_CNT + 4'(g)))),
            .cnt_wdata (cpu_wdata[CNT_W-1:0]),
            .sent      (in_done && (in_done_ep == EP_W'(g))),
            .ready     (in_rdy_q[g]),
            .count     (in_cnt[g]),
            .sent_ok   (in_sent_ok[g])
        );
        ep_out_slot #(.CNT_W(CNT_W)) u_out (
            .clk         (clk),
            .rst_n       (rst_n),
            .rx          (out_rx && (out_rx_ep == EP_W'(g))),
            .rx_len      (out_rx_len),
            .release_buf (wr_out_rdy && cpu_wdata[g]),
            .full        (out_rdy_q[g]),
            .count       (out_cnt[g]),
            .rx_ok       (out_rx_ok[g])
        );
    end

    always_comb begin
        irq_set            = '0;
        irq_set[IRQ_SOF]   = sof_valid;
        irq_set[IRQ_SETUP] = setup_valid;
        irq_set[IRQ_IN]    = |in_sent_ok;
        irq_set[IRQ_OUT]   = |out_rx_ok;
        irq_clr = (cpu_we && (cpu_addr == A_IRQ)) ? cpu_wdata[IRQ_N-1:0] : '0;
    end

    irq_status #(.NSRC(IRQ_N)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (irq_set),
        .clr_w1c (irq_clr),
        .stat    (irq_stat_q),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            toggle_q <= '0;
            dev_addr <= '0;
            frame_q  <= '0;
        end else begin
            if (cpu_we && (cpu_addr == A_TOGGLE)) toggle_q <= cpu_wdata[NUM_EP-1:0];
            if (cpu_we && (cpu_addr == A_DEVADR)) dev_addr <= cpu_wdata[DEV_W-1:0];
            if (sof_valid)                        frame_q  <= sof_frame;
        end
    end

    assign in_ack     = in_rdy_q[in_tok_ep];
    assign in_len     = in_cnt[in_tok_ep];
    assign in_pid_sel = toggle_q[in_tok_ep];
    assign out_ack    = !out_rdy_q[out_rx_ep];

    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr[3:2] == A_IN_CNT[3:2])
            cpu_rdata = DATA_W'(in_cnt[cpu_addr[EP_W-1:0]]);
        else if (cpu_addr[3:2] == A_OUT_CNT[3:2])
            cpu_rdata = DATA_W'(out_cnt[cpu_addr[EP_W-1:0]]);
        else begin
            case (cpu_addr)
                A_IN_RDY:  cpu_rdata = DATA_W'(in_rdy_q);
                A_OUT_RDY: cpu_rdata = DATA_W'(out_rdy_q);
                A_IRQ:     cpu_rdata = DATA_W'(irq_stat_q);
                A_TOGGLE:  cpu_rdata = DATA_W'(toggle_q);
                A_DEVADR:  cpu_rdata = DATA_W'(dev_addr);
                A_FRM_LO:  cpu_rdata = frame_q[DATA_W-1:0];
                A_FRM_HI:  cpu_rdata = DATA_W'(frame_q[FRAME_W-1:FRAME_W-FHI_W]);
                default:   cpu_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/usb_ep_regbank_chk.sv
module usb_ep_regbank_chk
    import usb_ep_regbank_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EP_W   = 2,
    parameter int DEV_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_we,
    input logic [3:0]        cpu_addr,
    input logic              in_done,
    input logic [EP_W-1:0]   in_done_ep,
    input logic              out_rx,
    input logic [EP_W-1:0]   out_rx_ep,
    input logic              out_ack,
    input logic              sof_valid,
    input logic              setup_valid,
    input logic              irq,
    input logic [NUM_EP-1:0] in_rdy_q,
    input logic [NUM_EP-1:0] out_rdy_q,
    input logic [IRQ_N-1:0]  irq_stat_q,
    input logic [NUM_EP-1:0] toggle_q,
    input logic [DEV_W-1:0]  dev_addr
);
    logic wr_in;
    assign wr_in = cpu_we && (cpu_addr == A_IN_RDY);

    p_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_done && !wr_in) |=> $stable(in_rdy_q));

    p_in_noclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_in && !in_done) |=> ((in_rdy_q & $past(in_rdy_q)) == $past(in_rdy_q)));

    p_in_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_done && in_rdy_q[in_done_ep] && !wr_in) |=> !in_rdy_q[$past(in_done_ep)]);

    p_in_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_done && in_rdy_q[in_done_ep]) |=> irq_stat_q[IRQ_IN]);

    p_out_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rx && out_ack) |=> (out_rdy_q[$past(out_rx_ep)] && irq_stat_q[IRQ_OUT]));

    p_sof_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sof_valid |=> irq_stat_q[IRQ_SOF]);

    p_setup_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |=> irq_stat_q[IRQ_SETUP]);

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(sof_valid || setup_valid || in_done || out_rx));

    p_toggle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && (cpu_addr == A_TOGGLE)) |=> $stable(toggle_q));

    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && (cpu_addr == A_DEVADR)) |=> $stable(dev_addr));
endmodule

bind usb_ep_regbank usb_ep_regbank_chk #(
    .NUM_EP (NUM_EP),
    .EP_W   (EP_W),
    .DEV_W  (DEV_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .in_done     (in_done),
    .in_done_ep  (in_done_ep),
    .out_rx      (out_rx),
    .out_rx_ep   (out_rx_ep),
    .out_ack     (out_ack),
    .sof_valid   (sof_valid),
    .setup_valid (setup_valid),
    .irq         (irq),
    .in_rdy_q    (in_rdy_q),
    .out_rdy_q   (out_rdy_q),
    .irq_stat_q  (irq_stat_q),
    .toggle_q    (toggle_q),
    .dev_addr    (dev_addr)
);

// File: tb/usb_ep_regbank_test.sv
module usb_ep_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [1:0]  in_tok_ep = '0;
    logic        in_ack;
    logic [7:0]  in_len;
    logic        in_pid_sel;
    logic        in_done = 1'b0;
    logic [1:0]  in_done_ep = '0;
    logic        out_rx = 1'b0;
    logic [1:0]  out_rx_ep = '0;
    logic [7:0]  out_rx_len = '0;
    logic        out_ack;
    logic        sof_valid = 1'b0;
    logic [10:0] sof_frame = '0;
    logic        setup_valid = 1'b0;
    logic [6:0]  dev_addr;
    logic        irq;

    usb_ep_regbank uut (.*);

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [7:0]  m_in_cnt [4];
    logic [7:0]  m_out_cnt [4];
    logic [3:0]  m_inrdy, m_outrdy, m_stat, m_tog;
    logic [6:0]  m_addr;
    logic [10:0] m_frame;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int a);
        case (a)
            0, 1, 2, 3: return m_in_cnt[a];
            4, 5, 6, 7: return m_out_cnt[a-4];
            8:  return {4'b0, m_inrdy};
            9:  return {4'b0, m_outrdy};
            10: return {4'b0, m_stat};
            11: return {4'b0, m_tog};
            12: return {1'b0, m_addr};
            13: return m_frame[7:0];
            14: return {5'b0, m_frame[10:8]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        if (a < 4)   return "R2 in count";
        if (a < 8)   return "R6 out count";
        case (a)
            8:  return "R3 R5 in ready";
            9:  return "R7 out ready";
            10: return "R8 status";
            11: return "R10 toggle";
            12: return "R11 device addr";
            13, 14: return "R12 frame";
            default: return "R13 unused";
        endcase
    endfunction

    task automatic check_all();
        for (int a = 0; a < 16; a++) begin
            cpu_addr = 4'(a);
            #1;
            check(tag_of(a), cpu_rdata, exp_read(a));
        end
        for (int e = 0; e < 4; e++) begin
            in_tok_ep = 2'(e);
            out_rx_ep = 2'(e);
            #1;
            check("R4 in_ack", in_ack, m_inrdy[e]);
            check("R2 in_len", in_len, m_in_cnt[e]);
            check("R10 in_pid_sel", in_pid_sel, m_tog[e]);
            check("R6 out_ack", out_ack, !m_outrdy[e]);
        end
        check("R9 irq", irq, m_stat != 4'h0);
        check("R11 dev_addr", dev_addr, m_addr);
    endtask

    task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                        input logic dn, input logic [1:0] dn_ep,
                        input logic rx, input logic [1:0] rx_ep, input logic [7:0] rx_len,
                        input logic sof, input logic [10:0] frm, input logic stp);
        logic [3:0] set_v, clr_v, n_in, n_out;
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_wdata = d;
        in_done = dn; in_done_ep = dn_ep;
        out_rx = rx; out_rx_ep = rx_ep; out_rx_len = rx_len;
        sof_valid = sof; sof_frame = frm; setup_valid = stp;
        // Model update from the pre-edge state
        set_v = '0;
        n_in = m_inrdy;
        if (dn && m_inrdy[dn_ep]) begin n_in[dn_ep] = 1'b0; set_v[2] = 1'b1; end
        if (we && a == 4'h8) n_in = n_in | d[3:0];
        n_out = m_outrdy;
        if (we && a == 4'h9) n_out = n_out & ~d[3:0];
        if (rx && !m_outrdy[rx_ep]) begin
            n_out[rx_ep] = 1'b1; m_out_cnt[rx_ep] = rx_len; set_v[3] = 1'b1;
        end
        if (sof) begin set_v[0] = 1'b1; m_frame = frm; end
        if (stp) set_v[1] = 1'b1;
        clr_v = (we && a == 4'hA) ? d[3:0] : 4'h0;
        m_stat = set_v | (m_stat & ~clr_v);
        m_inrdy = n_in;
        m_outrdy = n_out;
        if (we && a < 4'h4) m_in_cnt[a[1:0]] = d;
        if (we && a == 4'hB) m_tog = d[3:0];
        if (we && a == 4'hC) m_addr = d[6:0];
        @(posedge clk);
        #1;
        cpu_we = 1'b0; in_done = 1'b0; out_rx = 1'b0; sof_valid = 1'b0; setup_valid = 1'b0;
        check_all();
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, 2'd0, 1'b0, 2'd0, 8'd0, 1'b0, 11'd0, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_in_cnt[i] = '0; m_out_cnt[i] = '0; end
        m_inrdy = '0; m_outrdy = '0; m_stat = '0; m_tog = '0; m_addr = '0; m_frame = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        check_all();

        wr(4'h2, 8'h40);                       // R2 load count
        wr(4'h8, 8'h04);                       // R3 arm ep2
        wr(4'h8, 8'h00);                       // R3 zeros ignored
        step(1'b0, 4'h0, 8'h00, 1'b1, 2'd1, 1'b0, 2'd0, 8'd0, 1'b0, 11'd0, 1'b0); // R5 not armed
        step(1'b0, 4'h0, 8'h00, 1'b1, 2'd2, 1'b0, 2'd0, 8'd0, 1'b0, 11'd0, 1'b0); // R5 sent
        wr(4'h8, 8'h02);
        step(1'b1, 4'h8, 8'h02, 1'b1, 2'd1, 1'b0, 2'd0, 8'd0, 1'b0, 11'd0, 1'b0); // R5 re-arm wins
        step(1'b0, 4'h0, 8'h00, 1'b0, 2'd0, 1'b1, 2'd0, 8'h11, 1'b0, 11'd0, 1'b0); // R6 accept
        step(1'b0, 4'h0, 8'h00, 1'b0, 2'd0, 1'b1, 2'd0, 8'h22, 1'b0, 11'd0, 1'b0); // R6 NAK
        wr(4'h9, 8'h00);                       // R7 zeros ignored
        wr(4'h9, 8'h01);                       // R7 release
        step(1'b1, 4'hA, 8'h01, 1'b0, 2'd0, 1'b0, 2'd0, 8'd0, 1'b1, 11'h5A3, 1'b0); // R8 set wins
        step(1'b0, 4'h0, 8'h00, 1'b0, 2'd0, 1'b0, 2'd0, 8'd0, 1'b0, 11'd0, 1'b1);   // R8 setup
        wr(4'hA, 8'hFF);                       // R8 clear all, R9 irq low
        wr(4'hB, 8'h0A);                       // R10
        wr(4'hC, 8'hFF);                       // R11 7 bits kept
        wr(4'hF, 8'hFF);                       // R13

        void'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], 4'($urandom), 8'($urandom),
                 r[3:2] == 2'b00, r[5:4],
                 r[7:6] == 2'b00, r[9:8], 8'($urandom),
                 r[12:10] == 3'b000, 11'($urandom),
                 r[15:13] == 3'b000);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule